// File: doc/BRIEF.md
# Serial Register Access Port

This block gives a host a narrow path into a small bank of 8-bit control registers. The host uses a shift clock, one serial data line, a read strobe, a write strobe and three address lines. A read is framed by the read strobe going low. The block then presents the addressed register on the data line, least significant bit first, one bit for each shift-clock period. A write works the other way round. The host clocks bits in, least significant bit first, and then pulses the write strobe low. The rising edge of that pulse commits the collected byte to the addressed register.

All host-side pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer, and the block reacts to edges it detects in the synchronized copies. Each level of the host pins must therefore last at least three block-clock cycles. The data line is split into an output value and an output enable, so that a pad can drive the shared wire.

The register contents are a stub for test purposes. Read/write entries reset to zero. Entries flagged read-only return a fixed pattern and refuse serial writes.

Top module: `serial_reg_port`

## Requirements
- R1: After synchronous reset the data output enable is low, the data output is low, and every read/write register holds 0x00.
- R2: A falling edge of `rd_n` starts a read. The pin is then driven, and it first presents bit 0 of the register selected by `addr`.
- R3: During a read, each falling edge of `sclk` advances the pin to the next higher bit. After eight bits have been presented, the eighth falling edge releases the pin.
- R4: The pin is driven only while a read is in progress and `rd_n` is low. A rising edge of `rd_n` ends the read at once.
- R5: When no read is active, each rising edge of `sclk` samples `sdata_in` into a write shift register that fills LSB first. Edges of `sclk` during a read shift nothing in.
- R6: A rising edge of `wr_n` writes the write shift register into the register at `addr` and then clears the shift register.
- R7: If fewer than eight bits (n) were shifted in before the commit, the register receives those n bits in positions 8-n to 7, first bit lowest, and zeros below them.
- R8: Read-only entries (addresses 6 and 7 by default) read as 0xA0 plus the address and are left unchanged by serial writes.
- R9: If more than eight bits were shifted in, the register receives the last eight, with the earliest of them in bit 0.
- R10: The data output is low whenever the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host shift clock |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| addr | input | ADDR_W | Register address |
| sdata_in | input | 1 | Serial data from the pad |
| sdata_out | output | 1 | Serial data towards the pad |
| sdata_oe | output | 1 | Pad drive enable |

## Verification
The bench uses the default parameters: 8-bit data, a 3-bit address and read-only entries at 6 and 7. With these values every register can be written and read back within a short run. Writes of zero, three, eight and eleven bits exercise the partial fill and the overflow rules. The read-only pair shows that writes are refused. An aborted read and stray shift-clock edges during a read show that the pin is released and that no bits leak into the next write.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // Number of host pins passed through synchronizers.
  localparam int N_SYNC = 4;
  localparam int IDX_SCLK = 0;
  localparam int IDX_RD   = 1;
  localparam int IDX_WR   = 2;
  localparam int IDX_DIN  = 3;
  // Idle levels of the host pins, used as synchronizer reset values.
  localparam logic [N_SYNC-1:0] SYNC_RST = 4'b0110;

  // Fixed pattern returned by a read-only stub entry.
  function automatic logic [7:0] ro_word(input int idx);
    return 8'hA0 + 8'(idx);
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import srp_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (RO_MASK[i]) begin : g_ro
      assign ent[i] = DATA_W'(ro_word(i));
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                  q <= '0;
        else if (we && addr == ADDR_W'(i))        q <= wdata;
      end
      assign ent[i] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= ent[addr];
  end
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              rd_lvl,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic              wr_rise,
  input  logic              din,
  input  logic [DATA_W-1:0] rdata,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              dout,
  output logic              doe,
  output logic              rd_last
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              rd_active;
  logic [CNT_W-1:0]  rcnt;
  logic [DATA_W-1:0] rsr;
  logic [DATA_W-1:0] wsr;

  // Read engine: load on strobe fall, advance on shift-clock fall.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0;
      rcnt      <= '0;
      rsr       <= '0;
    end else if (rd_fall) begin
      rd_active <= 1'b1;
      rcnt      <= '0;
      rsr       <= rdata;
    end else if (rd_active && rd_rise) begin
      rd_active <= 1'b0;
    end else if (rd_active && sclk_fall) begin
      if (rcnt == LAST) begin
        rd_active <= 1'b0;
      end else begin
        rcnt <= rcnt + 1'b1;
        rsr  <= rsr >> 1;
      end
    end
  end

  // Write engine: fill from the top so the first bit ends lowest.
  always_ff @(posedge clk) begin
    if (rst) begin
      wsr <= '0;
    end else if (wr_rise) begin
      wsr <= '0;
    end else if (sclk_rise && !rd_active && rd_lvl) begin
      if (DATA_W > 1) wsr <= {din, wsr[DATA_W-1:1]};
      else            wsr <= DATA_W'(din);
    end
  end

  assign we      = wr_rise;
  assign wdata   = wsr;
  assign doe     = rd_active;
  assign dout    = rd_active & rsr[0];
  assign rd_last = (rcnt == LAST);
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe
);
  import srp_pkg::*;

  logic [N_SYNC-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {sdata_in, wr_n, rd_n, sclk};

  for (genvar k = 0; k < N_SYNC; k++) begin : g_sync
    srp_sync #(.RST_VAL(SYNC_RST[k])) u_sync (
      .clk (clk),
      .rst (rst),
      .din (pin_raw[k]),
      .lvl (pin_lvl[k]),
      .rise(pin_rise[k]),
      .fall(pin_fall[k])
    );
  end

  logic sclk_rise, sclk_fall, rd_lvl, rd_fall, rd_rise, wr_rise, din_s;
  assign sclk_rise = pin_rise[IDX_SCLK];
  assign sclk_fall = pin_fall[IDX_SCLK];
  assign rd_lvl    = pin_lvl[IDX_RD];
  assign rd_fall   = pin_fall[IDX_RD];
  assign rd_rise   = pin_rise[IDX_RD];
  assign wr_rise   = pin_rise[IDX_WR];
  assign din_s     = pin_lvl[IDX_DIN];

  logic              we, rd_last;
  logic [DATA_W-1:0] wdata, rdata;

  srp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RO_MASK(RO_MASK)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .addr (addr),
    .we   (we),
    .wdata(wdata),
    .rdata(rdata)
  );

  srp_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk      (clk),
    .rst      (rst),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .rd_lvl   (rd_lvl),
    .rd_fall  (rd_fall),
    .rd_rise  (rd_rise),
    .wr_rise  (wr_rise),
    .din      (din_s),
    .rdata    (rdata),
    .we       (we),
    .wdata    (wdata),
    .dout     (sdata_out),
    .doe      (sdata_oe),
    .rd_last  (rd_last)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker (
  input logic clk,
  input logic rst,
  input logic rd_lvl,
  input logic rd_fall,
  input logic rd_rise,
  input logic sclk_fall,
  input logic rd_last,
  input logic sdata_oe,
  input logic sdata_out
);
  a_r2_start_drives: assert property (@(posedge clk) disable iff (rst)
    rd_fall |=> sdata_oe);

  a_r3_release_after_eighth: assert property (@(posedge clk) disable iff (rst)
    (sdata_oe && rd_last && sclk_fall && !rd_fall && !rd_rise) |=> !sdata_oe);

  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    (sdata_oe && $past(sdata_oe) && !$past(sclk_fall) && !$past(rd_fall))
      |-> $stable(sdata_out));

  a_r4_oe_needs_rd: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> $past(!rd_lvl));

  a_r10_quiet_when_released: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !sdata_out);
endmodule

bind serial_reg_port srp_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_lvl   (rd_lvl),
  .rd_fall  (rd_fall),
  .rd_rise  (rd_rise),
  .sclk_fall(sclk_fall),
  .rd_last  (rd_last),
  .sdata_oe (sdata_oe),
  .sdata_out(sdata_out)
);

// File: tb/tb_serial_reg_port.sv
`timescale 1ns/1ps
module tb_serial_reg_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic       sdata_in = 1'b0;
  logic       sdata_out, sdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_reg_port dut (
    .clk(clk), .rst(rst), .sclk(sclk), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Full read; checks drive per bit, value and release.
  task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    logic       oe_ok;
    v = '0;
    oe_ok = 1'b1;
    addr = a;
    waitc(6);
    rd_n = 1'b0;
    waitc(6);
    for (int i = 0; i < 8; i++) begin
      v[i] = sdata_out;
      if (sdata_oe !== 1'b1) oe_ok = 1'b0;
      sclk = 1'b1;
      waitc(6);
      sclk = 1'b0;
      waitc(6);
    end
    chk({req, " read value"}, 16'(v), 16'(exp));
    chk("R3 drive during read", 16'(oe_ok), 16'd1);
    chk("R3 release after eighth bit", 16'(sdata_oe), 16'd0);
    rd_n = 1'b1;
    waitc(6);
  endtask

  // Shift n bits of val (LSB first), then pulse the write strobe.
  task automatic write_bits(input logic [2:0] a, input logic [15:0] val, input int n);
    logic drv;
    drv = 1'b0;
    addr = a;
    for (int i = 0; i < n; i++) begin
      sdata_in = val[i];
      waitc(3);
      sclk = 1'b1;
      waitc(3);
      if (sdata_oe !== 1'b0) drv = 1'b1;
      waitc(3);
      sclk = 1'b0;
      waitc(3);
    end
    wr_n = 1'b0;
    waitc(6);
    wr_n = 1'b1;
    waitc(6);
    chk("R4 no drive during write", 16'(drv), 16'd0);
  endtask

  function automatic logic [7:0] expect_word(input logic [15:0] val, input int n);
    logic [7:0] r;
    r = '0;
    if (n >= 8) begin
      for (int i = 0; i < 8; i++) r[i] = val[n-8+i];
    end else begin
      for (int i = 0; i < n; i++) r[8-n+i] = val[i];
    end
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    waitc(4);
    rst = 1'b0;
    waitc(2);
    chk("R1 oe after reset", 16'(sdata_oe), 16'd0);
    chk("R10 out after reset", 16'(sdata_out), 16'd0);
    for (int a = 0; a < 6; a++) read_check(3'(a), 8'h00, "R1 rw reg reset");
  endtask

  task automatic t_full_writes();
    logic [7:0] pat [6];
    pat[0] = 8'h5A; pat[1] = 8'hFF; pat[2] = 8'h01;
    pat[3] = 8'h80; pat[4] = 8'hC3; pat[5] = 8'h96;
    for (int a = 0; a < 6; a++) write_bits(3'(a), 16'(pat[a]), 8);
    for (int a = 0; a < 6; a++) read_check(3'(a), pat[a], "R5 R6 full write");
  endtask

  task automatic t_partial();
    write_bits(3'd1, 16'h0005, 3);
    read_check(3'd1, expect_word(16'h0005, 3), "R7 three-bit write");
    write_bits(3'd3, 16'h0001, 1);
    read_check(3'd3, expect_word(16'h0001, 1), "R7 one-bit write");
  endtask

  task automatic t_overflow();
    write_bits(3'd4, 16'h06B5, 11);
    read_check(3'd4, expect_word(16'h06B5, 11), "R9 eleven-bit write");
  endtask

  task automatic t_readonly();
    read_check(3'd6, 8'hA6, "R8 ro entry 6");
    read_check(3'd7, 8'hA7, "R8 ro entry 7");
    write_bits(3'd6, 16'h0011, 8);
    write_bits(3'd7, 16'h00EE, 8);
    read_check(3'd6, 8'hA6, "R8 ro write ignored 6");
    read_check(3'd7, 8'hA7, "R8 ro write ignored 7");
    read_check(3'd5, 8'h96, "R8 neighbour untouched");
  endtask

  // Shift-clock edges during a read must not load the write register.
  task automatic t_no_shift_in_read();
    write_bits(3'd2, 16'h003C, 8);
    sdata_in = 1'b1;
    read_check(3'd2, 8'h3C, "R5 setup");
    write_bits(3'd2, 16'h0000, 0);
    read_check(3'd2, 8'h00, "R5 no shift during read, R6 cleared");
  endtask

  task automatic t_abort_read();
    addr = 3'd0;
    waitc(6);
    rd_n = 1'b0;
    waitc(6);
    chk("R2 first bit driven", 16'({sdata_oe, sdata_out}), 16'({1'b1, 1'b0}));
    sclk = 1'b1; waitc(6); sclk = 1'b0; waitc(6);
    chk("R3 second bit", 16'({sdata_oe, sdata_out}), 16'({1'b1, 1'b1}));
    rd_n = 1'b1;
    waitc(6);
    chk("R4 release on strobe rise", 16'(sdata_oe), 16'd0);
    chk("R10 low when released", 16'(sdata_out), 16'd0);
    read_check(3'd0, 8'h5A, "R4 reg intact after abort");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_writes();
    t_abort_read();
    t_partial();
    t_overflow();
    t_readonly();
    t_no_shift_in_read();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule